// File: doc/BRIEF.md
# Effective Address Unit with Multi-Level Indirection

This block resolves the operand address of a 16-bit memory-reference instruction on a word-addressed machine with 15-bit addresses and 32K words of 16 bits. When it is idle it takes an instruction word and the program counter. It forms a direct address by placing a 10-bit displacement either in page zero or in the page that holds the program counter. If the instruction asks for indirection, the unit then walks a pointer chain through memory until it reads a word whose top bit is clear.

Memory is read through a request/grant port. The unit holds a request and its address until the memory grants it, and the memory supplies the data word in the grant cycle. Word locations 0 and 1 are shadowed by the two accumulators. A pointer that lands on either of them is answered from the accumulator input in one cycle, with no memory request. A depth counter stops a chain that never ends: after a set number of reads that all returned indirect words, the unit raises an error pulse instead of a done pulse and returns to idle.

Top module: `ea_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, reqReady is 1 and done, depthErr and memReq are all 0.
- R2: With instruction bit 10 = 0 (page zero), effAddr bits 14..10 are zero and bits 9..0 equal instruction bits 9..0; program counter and instruction bits 14..11 have no effect.
- R3: With instruction bit 10 = 1 (current page), effAddr bits 14..10 equal program counter bits 14..10 and bits 9..0 equal instruction bits 9..0.
- R4: With instruction bit 15 = 0 (direct), done is high in the cycle right after the accepting clock edge, and no memory request is made.
- R5: Each indirect level through memory issues exactly one read with memAddr equal to the current pointer. memReq and memAddr stay steady until memGnt, and the word on memRdData is taken in the grant cycle.
- R6: The chain ends at the first fetched word with bit 15 = 0. effAddr then equals that word's bits 14..0, and done rises in the cycle after the word is taken.
- R7: A pointer of 0 reads accA and a pointer of 1 reads accB. Each such level takes one cycle and raises no memReq.
- R8: If MAX_DEPTH consecutive fetched words all have bit 15 = 1, depthErr pulses for one cycle and done does not rise. A chain whose MAX_DEPTH-th word has bit 15 = 0 completes normally.
- R9: reqReady is 1 only while idle. reqValid raised while the unit is busy is ignored and does not change the result in progress.
- R10: done and depthErr are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start a resolution (taken when reqReady is 1) |
| reqReady | output | 1 | Unit idle and able to accept |
| instrWord | input | 16 | Memory-reference instruction word |
| progCounter | input | 15 | Program counter of the instruction |
| accA | input | 16 | Accumulator shadowing word 0 |
| accB | input | 16 | Accumulator shadowing word 1 |
| memReq | output | 1 | Memory read request |
| memAddr | output | 15 | Memory read address |
| memGnt | input | 1 | Memory grant; data valid in the same cycle |
| memRdData | input | 16 | Memory read data |
| done | output | 1 | One-cycle pulse: effAddr holds the result |
| effAddr | output | 15 | Resolved operand address |
| depthErr | output | 1 | One-cycle pulse: chain exceeded MAX_DEPTH |

## Verification
The bench aims at chain lengths of exactly MAX_DEPTH and one more, at a self-pointing word, and at chains that pass through the accumulator shadow. A depth counter that is off by one would either reject a legal 64-level chain or run one extra read. A missing alias would put a memory read on address 0 or 1. Grants are also stalled, to catch a design that takes data without a grant or moves its address while it waits. A request is held high while the unit is busy, to expose a design that restarts in mid-chain. The page-select cases set opposing program counter and opcode bits, so that leakage of the page or opcode bits into the address shows up.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [1:0] {
    EA_IDLE  = 2'd0,
    EA_WALK  = 2'd1,
    EA_FIN   = 2'd2,
    EA_FAULT = 2'd3
  } eaState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureDirect;  // load pointer/result from the formed address, clear depth
    logic advancePtr;     // follow fetched indirect word, bump depth
    logic latchFinal;     // fetched word ends the chain
  } eaStrobes_t;

endpackage

// File: rtl/ea_page_form.sv
module ea_page_form #(
  parameter int ADDR_W = 15,
  parameter int DISP_W = 10
) (
  input  logic [ADDR_W-DISP_W-1:0] pcPage,
  input  logic [DISP_W-1:0]        disp,
  input  logic                     curPage,
  output logic [ADDR_W-1:0]        directAddr
);
  localparam int PAGE_W = ADDR_W - DISP_W;

  assign directAddr[DISP_W-1:0] = disp;

  // page bits are forced to zero unless the current page is selected
  for (genvar g = 0; g < PAGE_W; g++) begin : gPage
    assign directAddr[DISP_W+g] = curPage & pcPage[g];
  end

endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 16,
  parameter int DISP_W    = 10,
  parameter int MAX_DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  eaStrobes_t               strobe,
  input  logic [DISP_W:0]          instrLow,
  input  logic [ADDR_W-DISP_W-1:0] pcPage,
  input  logic [DATA_W-1:0]        accA,
  input  logic [DATA_W-1:0]        accB,
  input  logic [DATA_W-1:0]        memRdData,
  output logic [ADDR_W-1:0]        ptrAddr,
  output logic [ADDR_W-1:0]        effAddr,
  output logic                     ptrIsAcc,
  output logic                     wordIndirect,
  output logic                     atLimit
);
  localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);

  logic [ADDR_W-1:0]  directAddr;
  logic [DATA_W-1:0]  srcWord;
  logic [DEPTH_W-1:0] depthCnt;

  ea_page_form #(
    .ADDR_W(ADDR_W),
    .DISP_W(DISP_W)
  ) u_page (
    .pcPage    (pcPage),
    .disp      (instrLow[DISP_W-1:0]),
    .curPage   (instrLow[DISP_W]),
    .directAddr(directAddr)
  );

  // words 0 and 1 are shadowed by the accumulators
  assign ptrIsAcc = (ptrAddr[ADDR_W-1:1] == '0);

  always_comb begin
    if (!ptrIsAcc)       srcWord = memRdData;
    else if (ptrAddr[0]) srcWord = accB;
    else                 srcWord = accA;
  end

  assign wordIndirect = srcWord[DATA_W-1];
  assign atLimit      = (depthCnt == DEPTH_W'(MAX_DEPTH - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrAddr  <= '0;
      effAddr  <= '0;
      depthCnt <= '0;
    end else if (strobe.captureDirect) begin
      ptrAddr  <= directAddr;
      effAddr  <= directAddr;
      depthCnt <= '0;
    end else if (strobe.advancePtr) begin
      ptrAddr  <= srcWord[ADDR_W-1:0];
      depthCnt <= depthCnt + 1'b1;
    end else if (strobe.latchFinal) begin
      effAddr  <= srcWord[ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqIndirect,
  input  logic       ptrIsAcc,
  input  logic       memGnt,
  input  logic       wordIndirect,
  input  logic       atLimit,
  output eaStrobes_t strobe,
  output logic       reqReady,
  output logic       memReq,
  output logic       done,
  output logic       depthErr
);
  eaState_t state, stateNext;
  logic     wordTaken;

  assign wordTaken = (state == EA_WALK) && (ptrIsAcc || memGnt);

  always_comb begin
    stateNext = state;
    unique case (state)
      EA_IDLE:  if (reqValid) stateNext = reqIndirect ? EA_WALK : EA_FIN;
      EA_WALK:  if (wordTaken) begin
                  if (!wordIndirect) stateNext = EA_FIN;
                  else if (atLimit)  stateNext = EA_FAULT;
                end
      EA_FIN:   stateNext = EA_IDLE;
      EA_FAULT: stateNext = EA_IDLE;
      default:  stateNext = EA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= EA_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.captureDirect = (state == EA_IDLE) && reqValid;
    strobe.advancePtr    = wordTaken && wordIndirect && !atLimit;
    strobe.latchFinal    = wordTaken && !wordIndirect;
  end

  assign reqReady = (state == EA_IDLE);
  assign memReq   = (state == EA_WALK) && !ptrIsAcc;
  assign done     = (state == EA_FIN);
  assign depthErr = (state == EA_FAULT);

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 16,
  parameter int DISP_W    = 10,
  parameter int MAX_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [ADDR_W-1:0] progCounter,
  input  logic [DATA_W-1:0] accA,
  input  logic [DATA_W-1:0] accB,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memGnt,
  input  logic [DATA_W-1:0] memRdData,
  output logic              done,
  output logic [ADDR_W-1:0] effAddr,
  output logic              depthErr
);
  eaStrobes_t strobe;
  logic       ptrIsAcc, wordIndirect, atLimit;
  logic [ADDR_W-1:0] ptrAddr;

  // opcode field and in-page counter bits play no part in the address
  logic unusedBits;
  assign unusedBits = ^{instrWord[DATA_W-2:DISP_W+1], progCounter[DISP_W-1:0]};

  ea_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqIndirect (instrWord[DATA_W-1]),
    .ptrIsAcc    (ptrIsAcc),
    .memGnt      (memGnt),
    .wordIndirect(wordIndirect),
    .atLimit     (atLimit),
    .strobe      (strobe),
    .reqReady    (reqReady),
    .memReq      (memReq),
    .done        (done),
    .depthErr    (depthErr)
  );

  ea_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DISP_W   (DISP_W),
    .MAX_DEPTH(MAX_DEPTH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .instrLow    (instrWord[DISP_W:0]),
    .pcPage      (progCounter[ADDR_W-1:DISP_W]),
    .accA        (accA),
    .accB        (accB),
    .memRdData   (memRdData),
    .ptrAddr     (ptrAddr),
    .effAddr     (effAddr),
    .ptrIsAcc    (ptrIsAcc),
    .wordIndirect(wordIndirect),
    .atLimit     (atLimit)
  );

  assign memAddr = ptrAddr;

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  parameter int DISP_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [DATA_W-1:0] instrWord,
  input logic [ADDR_W-1:0] progCounter,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memGnt,
  input logic              done,
  input logic [ADDR_W-1:0] effAddr,
  input logic              depthErr
);
  logic unusedChk;
  assign unusedChk = ^{instrWord[DATA_W-2:DISP_W+1], progCounter[DISP_W-1:0]};

  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && depthErr));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    depthErr |=> !depthErr);

  // R5
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && $stable(memAddr)));

  // R7
  acc_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[ADDR_W-1:1] != '0));

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R4
  direct_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !instrWord[DATA_W-1]) |=> (done && !memReq));

  // R2
  page_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !instrWord[DATA_W-1] && !instrWord[DISP_W])
      |=> (effAddr[ADDR_W-1:DISP_W] == '0 &&
           effAddr[DISP_W-1:0] == $past(instrWord[DISP_W-1:0])));

  // R3
  cur_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !instrWord[DATA_W-1] && instrWord[DISP_W])
      |=> (effAddr[ADDR_W-1:DISP_W] == $past(progCounter[ADDR_W-1:DISP_W]) &&
           effAddr[DISP_W-1:0] == $past(instrWord[DISP_W-1:0])));

endmodule

bind ea_unit ea_unit_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .DISP_W(DISP_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .instrWord  (instrWord),
  .progCounter(progCounter),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .memGnt     (memGnt),
  .done       (done),
  .effAddr    (effAddr),
  .depthErr   (depthErr)
);

// File: tb/sim_ea_unit.sv
`timescale 1ns/1ps
module sim_ea_unit;
  localparam int MAXD = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [14:0] progCounter = '0;
  logic [15:0] accA = '0, accB = '0;
  logic        memGnt = 1'b0;
  logic [15:0] memRdData = '0;
  logic        reqReady, memReq, done, depthErr;
  logic [14:0] memAddr, effAddr;

  int testsRun = 0, testsFailed = 0;
  int stallMode = 0, stallCnt = 0;
  logic [15:0] memStore [int];

  always #2.5 clk = ~clk;

  ea_unit #(.MAX_DEPTH(MAXD)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .instrWord(instrWord), .progCounter(progCounter), .accA(accA), .accB(accB),
    .memReq(memReq), .memAddr(memAddr), .memGnt(memGnt), .memRdData(memRdData),
    .done(done), .effAddr(effAddr), .depthErr(depthErr));

  function automatic logic [15:0] memRead(input logic [14:0] a);
    if (memStore.exists(int'(a))) return memStore[int'(a)];
    return 16'h0000;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory side: grant pattern and read data
  always @(negedge clk) begin
    stallCnt++;
    memGnt    = (stallMode == 0) ? 1'b1 : (stallCnt % 3 == 0);
    memRdData = memRead(memAddr);
  end

  // behavioural reference: 0 idle, 1 walking, 2 finished, 3 fault
  int          mPhase = 0, mLevels = 0;
  logic [14:0] mPtr = '0, mRes = '0;

  always @(posedge clk) begin
    logic [15:0] w;
    logic [14:0] a;
    bit got;
    if (!rstN) begin
      mPhase = 0; mPtr = '0; mRes = '0;
    end else begin
      case (mPhase)
        0: if (reqValid) begin
             a = {instrWord[10] ? progCounter[14:10] : 5'd0, instrWord[9:0]};
             if (instrWord[15]) begin mPhase = 1; mPtr = a; mLevels = 0; end
             else begin mPhase = 2; mRes = a; end
           end
        1: begin
             got = (mPtr <= 15'd1) ? 1'b1 : memGnt;
             w = (mPtr == 15'd0) ? accA : (mPtr == 15'd1) ? accB : memRead(mPtr);
             if (got) begin
               mLevels++;
               if (!w[15]) begin mRes = w[14:0]; mPhase = 2; end
               else if (mLevels == MAXD) mPhase = 3;
               else mPtr = w[14:0];
             end
           end
        default: mPhase = 0;
      endcase
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN) begin
      check(reqReady == (mPhase == 0), "R9", "reqReady", reqReady, mPhase == 0);
      check(memReq == (mPhase == 1 && mPtr > 15'd1), "R5", "memReq", memReq,
            mPhase == 1 && mPtr > 15'd1);
      if (mPhase == 1 && mPtr > 15'd1)
        check(memAddr == mPtr, "R5", "memAddr", memAddr, mPtr);
      check(done == (mPhase == 2), "R6", "done", done, mPhase == 2);
      check(depthErr == (mPhase == 3), "R8", "depthErr", depthErr, mPhase == 3);
      check(!(done && depthErr), "R10", "done&depthErr", done && depthErr, 0);
      if (mPhase == 2) check(effAddr == mRes, "R6", "effAddr", effAddr, mRes);
    end
  end

  task automatic runCase(input string tag, input logic [15:0] instr,
                         input logic [14:0] pc, input bit hammer, input bit expErr,
                         input logic [14:0] expAddr, output int lat);
    bit seenErr = 0, seenDone = 0;
    logic [14:0] gotAddr = '0;
    reqValid = 1'b1; instrWord = instr; progCounter = pc;
    lat = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); lat++;
      if (done || depthErr) begin
        seenDone = done; seenErr = depthErr; gotAddr = effAddr;
        reqValid = 1'b0;
        break;
      end
      if (!hammer) reqValid = 1'b0;
      else instrWord = 16'h0001;
    end
    check(seenDone != seenErr, tag, "completion seen", {seenDone, seenErr}, {!expErr, expErr});
    check(seenErr == expErr, tag, "error outcome", seenErr, expErr);
    if (!expErr) check(gotAddr == expAddr, tag, "final address", gotAddr, expAddr);
    @(negedge clk);
  endtask

  initial begin
    #500000;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(reqReady && !done && !depthErr && !memReq, "R1", "reset outputs",
          {reqReady, done, depthErr, memReq}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !done && !depthErr && !memReq, "R1", "after reset",
          {reqReady, done, depthErr, memReq}, 4'b1000);

    // R2 page zero, pc and opcode bits set but ignored
    runCase("R2", 16'h7955, 15'h7C00, 0, 0, 15'h0155, lat);
    check(lat == 1, "R4", "direct latency", lat, 1);
    // R3 current page
    runCase("R3", 16'h4FFF, 15'h6AB0, 0, 0, 15'h6BFF, lat);
    check(lat == 1, "R4", "direct latency", lat, 1);
    runCase("R3", 16'h0412, 15'h03FF, 0, 0, 15'h0012, lat);

    // R6 single indirect level
    memStore[16'h0010] = 16'h3456;
    runCase("R6", 16'h8010, 15'h0000, 0, 0, 15'h3456, lat);
    check(lat == 2, "R6", "one-level latency", lat, 2);

    // R5 multi-level on the current page with stalled grants
    stallMode = 1;
    memStore[16'h5020] = 16'h8300;
    memStore[16'h0300] = 16'h8400;
    memStore[16'h0400] = 16'h2222;
    runCase("R5", 16'h8420, 15'h5000, 0, 0, 15'h2222, lat);
    check(lat > 4, "R5", "stalled latency grows", lat, 5);
    stallMode = 0;

    // R7 chain entirely through the accumulators
    accB = 16'h8000; accA = 16'h0ABC;
    runCase("R7", 16'h8001, 15'h0000, 0, 0, 15'h0ABC, lat);
    check(lat == 3, "R7", "accumulator latency", lat, 3);
    // R7 memory word pointing at accumulator B
    accB = 16'h1111;
    memStore[16'h0050] = 16'h8001;
    runCase("R7", 16'h8050, 15'h0000, 0, 0, 15'h1111, lat);

    // R8 chain of exactly MAXD reads
    for (int i = 0; i < MAXD - 1; i++) memStore[100 + i] = 16'h8000 | 16'(101 + i);
    memStore[100 + MAXD - 1] = 16'h1234;
    runCase("R8", 16'h8064, 15'h0000, 0, 0, 15'h1234, lat);
    check(lat == MAXD + 1, "R8", "max-depth latency", lat, MAXD + 1);

    // R9 request held high while busy must not disturb the walk
    runCase("R9", 16'h8064, 15'h0000, 1, 0, 15'h1234, lat);

    // R8 one level too many
    memStore[100 + MAXD - 1] = 16'h8000 | 16'(100 + MAXD);
    memStore[100 + MAXD]     = 16'h0055;
    runCase("R8", 16'h8064, 15'h0000, 0, 1, 15'h0000, lat);
    // R8 self-pointing word
    memStore[200] = 16'h80C8;
    runCase("R8", 16'h80C8, 15'h0000, 0, 1, 15'h0000, lat);
    check(reqReady, "R10", "idle after fault", reqReady, 1);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule